// File: doc/BRIEF.md
# Clocked Serial Full-Duplex Master

This block is a byte-wide synchronous serial engine that drives its own serial clock. During one frame it sends a byte on `txd` and receives a byte from `rxd` at the same time, least significant bit first. The serial clock is a fixed division of the system clock. It rests high between frames. `txd` changes on each falling edge, and `rxd` is captured on each rising edge.

The processor side has two streams. Bytes are written through a valid/ready transmit port into a transmit holding stage. Received bytes come out through a valid/ready receive port from a receive holding stage. A frame starts only when a held transmit byte exists and the receive side can take the byte that frame will produce. While either condition is missing, the serial clock stays parked high. This gives back-pressure in both directions.

In single-buffer mode the transmit port is closed while a frame runs. The next frame needs both a read of the received byte and a new transmit write, in either order. In double-buffer mode a byte may be written while a frame is in progress, and frames follow one another until the transmit holding stage runs dry or the receive holding stage is still occupied when a new byte arrives. The byte that arrives in that case waits in the receive shift stage, and the clock stays stopped until the processor reads the holding stage.

Top module: `sio_duplex_master`

## Requirements
- R1: After reset, `sclk` and `txd` are high, `tx_empty` is 1, `rx_full` is 0, `tx_ready` is 1 and both interrupt outputs are 0.
- R2: While `duplex_en` is 0, no frame starts. A byte accepted on the transmit port is kept (`tx_empty` stays 0) and `sclk` stays high.
- R3: Bits go out and come in least significant bit first. `txd` changes only while `sclk` is low (at its falling edge), and `rxd` is sampled as `sclk` rises. Each `sclk` half-period is `HALF` system cycles.
- R4: When the engine is idle with both holding stages empty, a write accepted at edge t gives a one-cycle `tx_irq` visible after edge t+1+16*HALF. `rx_irq` follows one cycle later, together with `rx_valid`, and `rx_data` holds the received byte.
- R5: In single-buffer mode (`dbl_buf`=0), `tx_ready` is 0 while a frame is in progress.
- R6: In single-buffer mode, a frame does not start while the previous received byte is unread, even if a transmit byte is waiting. It starts on the cycle after the read handshake.
- R7: In double-buffer mode (`dbl_buf`=1), a byte can be written during a frame. If the receive holding stage is free, the next frame starts one cycle after the previous one ends, so consecutive `tx_irq` pulses are 1+16*HALF cycles apart.
- R8: In double-buffer mode, when no transmit byte is held at a frame boundary, `sclk` stays high and `tx_empty` reads 1.
- R9: In double-buffer mode, a byte finished while the receive holding stage is full stays in the shift stage with no `rx_irq`, and no new frame starts. One cycle after the holding stage is read, that byte moves up with `rx_irq`, and a waiting transmit byte starts its frame on the same edge.
- R10: A transmit handshake (`tx_valid` and `tx_ready` high at an edge) clears `tx_empty`. A receive handshake (`rx_valid` and `rx_ready`) clears `rx_full` unless a waiting byte moves in. `tx_ready` is never 1 while `tx_empty` is 0.
- R11: `tx_irq` and `rx_irq` are single system-cycle pulses, and `rx_irq` is only high while `rx_full` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| duplex_en | input | 1 | Full-duplex enable; 0 blocks frame starts |
| dbl_buf | input | 1 | 0 = single-buffer mode, 1 = double-buffer mode |
| tx_valid | input | 1 | Transmit byte offered |
| tx_data | input | W | Transmit byte |
| tx_ready | output | 1 | Transmit holding stage can accept |
| rx_valid | output | 1 | Received byte available |
| rx_data | output | W | Received byte |
| rx_ready | input | 1 | Processor takes the received byte |
| sclk | output | 1 | Serial clock, idle high |
| txd | output | 1 | Serial transmit data, idle high |
| rxd | input | 1 | Serial receive data |
| tx_irq | output | 1 | Transmit-complete pulse |
| rx_irq | output | 1 | Receive-complete pulse |
| tx_empty | output | 1 | Transmit holding stage empty |
| rx_full | output | 1 | Receive holding stage occupied |

## Verification
With the default `HALF` of 2, a write accepted on an idle engine produces `tx_irq` 33 cycles later, and `rx_irq` arrives one cycle after that. The bench counts falling-edge samples from the acceptance edge until the pulse and compares the count with 1+16*HALF. Consecutive double-buffer frames are timed the same way between `tx_irq` pulses. After a read that releases a stall, `sclk` is due low, or `rx_irq` is due, exactly one sample later. Every output is sampled on the falling system-clock edge, one half cycle after the register that drives it updates. A serial-side model counts falls of `sclk` so that stall windows can be shown to contain no clock activity.

// File: rtl/sio_pkg.sv
package sio_pkg;
  // Serial-clock events produced by the sequencer, valid for one system cycle
  typedef struct packed {
    logic rise;  // sclk goes high at this edge: sample receive line
    logic fall;  // sclk goes low mid-frame: present next transmit bit
    logic last;  // frame ends at this edge
  } sio_evt_t;
endpackage

// File: rtl/sio_seq.sv
module sio_seq
  import sio_pkg::*;
#(
  parameter int HALF = 2,
  parameter int BITS = 8
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     start,
  output logic     sclk,
  output logic     busy,
  output sio_evt_t evt
);
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam int BW = (BITS > 1) ? $clog2(BITS) : 1;

  logic [CW-1:0] cnt;
  logic [BW-1:0] bitn;
  logic          tick;

  assign tick     = busy && (cnt == CW'(HALF - 1));
  assign evt.rise = tick && !sclk;
  assign evt.last = tick && sclk && (bitn == BW'(BITS - 1));
  assign evt.fall = tick && sclk && (bitn != BW'(BITS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      bitn <= '0;
      sclk <= 1'b1;
      busy <= 1'b0;
    end else if (start) begin
      busy <= 1'b1;
      sclk <= 1'b0;
      cnt  <= '0;
      bitn <= '0;
    end else if (busy) begin
      if (tick) begin
        cnt <= '0;
        if (evt.rise) begin
          sclk <= 1'b1;
        end else if (evt.last) begin
          busy <= 1'b0;
        end else begin
          sclk <= 1'b0;
          bitn <= bitn + 1'b1;
        end
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/sio_tx.sv
module sio_tx #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         load,
  input  logic         shift,
  input  logic         done,
  output logic         hold_v,
  output logic         txd
);
  logic [W-1:0] hold;
  logic [W-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold   <= '0;
      hold_v <= 1'b0;
      sh     <= '0;
      txd    <= 1'b1;
    end else begin
      if (wr_en) begin
        hold   <= wr_data;
        hold_v <= 1'b1;
      end else if (load) begin
        hold_v <= 1'b0;
      end
      if (load) begin
        txd <= hold[0];
        sh  <= hold >> 1;
      end else if (shift) begin
        txd <= sh[0];
        sh  <= sh >> 1;
      end else if (done) begin
        txd <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/sio_rx.sv
module sio_rx #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         rxd,
  input  logic         sample,
  input  logic         done,
  input  logic         rd,
  output logic         hold_v,
  output logic [W-1:0] hold,
  output logic         pend,
  output logic         irq
);
  logic [W-1:0] sh;
  logic         move;

  assign move = pend && !hold_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh     <= '0;
      hold   <= '0;
      hold_v <= 1'b0;
      pend   <= 1'b0;
      irq    <= 1'b0;
    end else begin
      irq <= move;
      if (sample) sh <= {rxd, sh[W-1:1]};
      if (done) pend <= 1'b1;
      else if (move) pend <= 1'b0;
      if (move) begin
        hold   <= sh;
        hold_v <= 1'b1;
      end else if (rd) begin
        hold_v <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/sio_duplex_master.sv
module sio_duplex_master
  import sio_pkg::*;
#(
  parameter int W    = 8,
  parameter int HALF = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         duplex_en,
  input  logic         dbl_buf,
  input  logic         tx_valid,
  input  logic [W-1:0] tx_data,
  output logic         tx_ready,
  output logic         rx_valid,
  output logic [W-1:0] rx_data,
  input  logic         rx_ready,
  output logic         sclk,
  output logic         txd,
  input  logic         rxd,
  output logic         tx_irq,
  output logic         rx_irq,
  output logic         tx_empty,
  output logic         rx_full
);
  sio_evt_t evt;
  logic     busy, start, rx_free;
  logic     tx_hold_v, rx_hold_v, rx_pend;

  // Receive side can take a new frame's byte: double mode lets the waiting
  // byte move up on the start edge, single mode needs both stages clear.
  assign rx_free  = dbl_buf ? (!rx_pend || !rx_hold_v) : (!rx_pend && !rx_hold_v);
  assign start    = !busy && duplex_en && tx_hold_v && rx_free;
  assign tx_ready = !tx_hold_v && (dbl_buf || !busy);
  assign tx_empty = !tx_hold_v;
  assign rx_valid = rx_hold_v;
  assign rx_full  = rx_hold_v;

  sio_seq #(.HALF(HALF), .BITS(W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start),
    .sclk(sclk), .busy(busy), .evt(evt)
  );

  sio_tx #(.W(W)) u_tx (
    .clk(clk), .rst_n(rst_n),
    .wr_en(tx_valid && tx_ready), .wr_data(tx_data),
    .load(start), .shift(evt.fall), .done(evt.last),
    .hold_v(tx_hold_v), .txd(txd)
  );

  sio_rx #(.W(W)) u_rx (
    .clk(clk), .rst_n(rst_n), .rxd(rxd),
    .sample(evt.rise), .done(evt.last), .rd(rx_valid && rx_ready),
    .hold_v(rx_hold_v), .hold(rx_data), .pend(rx_pend), .irq(rx_irq)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tx_irq <= 1'b0;
    else        tx_irq <= evt.last;
  end
endmodule

// File: rtl/sio_duplex_master_chk.sv
module sio_duplex_master_chk (
  input logic clk,
  input logic rst_n,
  input logic duplex_en,
  input logic dbl_buf,
  input logic tx_ready,
  input logic tx_empty,
  input logic sclk,
  input logic txd,
  input logic tx_irq,
  input logic rx_irq,
  input logic rx_full,
  input logic busy,
  input logic rx_pend
);
  // R1: clock rests high whenever no frame runs
  p_idle_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> sclk);
  // R2: disabled engine never leaves idle
  p_no_start_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !duplex_en) |=> sclk);
  // R3: transmit line moves only with the clock low
  p_txd_on_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !$stable(txd)) |-> !sclk);
  // R5: single-buffer port closed during a frame
  p_single_closed_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !dbl_buf) |-> !tx_ready);
  // R9: waiting byte behind a full holding stage blocks the next frame
  p_rx_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_pend && rx_full && !busy) |=> !busy);
  // R10: ready implies an empty holding stage
  p_ready_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> tx_empty);
  // R11: interrupt pulses last one cycle
  p_tx_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    tx_irq |=> !tx_irq);
  p_rx_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |=> !rx_irq);
  p_rx_irq_full_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |-> rx_full);
endmodule

bind sio_duplex_master sio_duplex_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .duplex_en(duplex_en), .dbl_buf(dbl_buf),
  .tx_ready(tx_ready), .tx_empty(tx_empty), .sclk(sclk), .txd(txd),
  .tx_irq(tx_irq), .rx_irq(rx_irq), .rx_full(rx_full),
  .busy(busy), .rx_pend(rx_pend)
);

// File: tb/sio_duplex_master_bench.sv
module sio_duplex_master_bench;
  localparam int PERIOD = 10;
  localparam int HALF   = 2;
  localparam int FRAME  = 1 + 16 * HALF;
  localparam int NV     = 6;
  localparam logic [7:0] VEC [NV] = '{8'hA5, 8'h01, 8'h80, 8'hFF, 8'h00, 8'h3C};

  logic clk = 1'b0, rst_n = 1'b0;
  logic duplex_en = 1'b1, dbl_buf = 1'b0;
  logic tx_valid = 1'b0, rx_ready = 1'b0, rxd = 1'b1;
  logic [7:0] tx_data = '0;
  logic tx_ready, rx_valid, sclk, txd, tx_irq, rx_irq, tx_empty, rx_full;
  logic [7:0] rx_data;

  int total = 0, bad = 0;
  int nfall = 0, scnt = 0, sbit = 0, fidx = 0;
  logic prev_sclk = 1'b1;
  logic [7:0] sbyte, mbyte;
  logic [7:0] cap [32];

  always #(PERIOD/2) clk = ~clk;

  sio_duplex_master #(.W(8), .HALF(HALF)) u_sio_duplex_master (
    .clk(clk), .rst_n(rst_n), .duplex_en(duplex_en), .dbl_buf(dbl_buf),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
    .sclk(sclk), .txd(txd), .rxd(rxd), .tx_irq(tx_irq), .rx_irq(rx_irq),
    .tx_empty(tx_empty), .rx_full(rx_full)
  );

  function automatic logic [7:0] slave_of(input int k);
    return 8'h5A ^ 8'(k * 37);
  endfunction

  // Serial-side model: drives rxd after sclk falls, captures txd after it rises
  always @(negedge clk) begin
    if (prev_sclk && !sclk) begin
      nfall++;
      if (sbit == 0) sbyte = slave_of(scnt);
      rxd <= sbyte[sbit];
    end else if (!prev_sclk && sclk) begin
      mbyte[sbit] = txd;
      sbit++;
      if (sbit == 8) begin
        cap[scnt] = mbyte;
        scnt++;
        sbit = 0;
      end
    end
    prev_sclk = sclk;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk);
    tx_valid = 1'b1;
    tx_data  = b;
    while (!tx_ready) @(negedge clk);
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic rd(output logic [7:0] d);
    @(negedge clk);
    rx_ready = 1'b1;
    d = rx_data;
    @(negedge clk);
    rx_ready = 1'b0;
  endtask

  task automatic wait_tx(output int n);
    n = 0;
    while (!tx_irq) begin @(negedge clk); n++; end
  endtask

  task automatic quiet(input int cyc, input string req);
    int f0 = nfall;
    repeat (cyc) @(negedge clk);
    chk(nfall == f0 && sclk, req, nfall - f0, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog expired");
    total++; bad++;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n;
    logic [7:0] d;
    repeat (3) @(negedge clk);
    chk(sclk && txd, "R1 idle lines", {sclk, txd}, 2'b11);
    chk(tx_empty && !rx_full && tx_ready && !rx_valid, "R1 flags",
        {tx_empty, rx_full, tx_ready, rx_valid}, 4'b1010);
    chk(!tx_irq && !rx_irq, "R1 irqs", {tx_irq, rx_irq}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // Vector table: single-buffer frames with exact timing
    for (int i = 0; i < NV; i++) begin
      send(VEC[i]);
      chk(!tx_ready, "R5 port closed in frame", tx_ready, 0);
      wait_tx(n);
      chk(n == FRAME, "R4 tx_irq delay", n, FRAME);
      @(negedge clk);
      chk(!tx_irq, "R11 tx pulse width", tx_irq, 0);
      chk(rx_irq && rx_valid, "R4 rx_irq follows", {rx_irq, rx_valid}, 2'b11);
      chk(rx_data == slave_of(fidx), "R4 rx data", rx_data, slave_of(fidx));
      chk(cap[fidx] == VEC[i], "R3 txd lsb first", cap[fidx], VEC[i]);
      @(negedge clk);
      chk(!rx_irq, "R11 rx pulse width", rx_irq, 0);
      rd(d);
      chk(!rx_full, "R10 read clears full", rx_full, 0);
      fidx++;
    end

    // R2: disabled engine holds the byte
    duplex_en = 1'b0;
    send(8'h96);
    chk(!tx_empty, "R10 write clears empty", tx_empty, 1);
    quiet(40, "R2 no clock while disabled");
    chk(!tx_empty, "R2 byte kept", tx_empty, 1);
    duplex_en = 1'b1;
    wait_tx(n);
    @(negedge clk);
    rd(d);
    chk(d == slave_of(fidx) && cap[fidx] == 8'h96, "R2 frame after enable", d, slave_of(fidx));
    fidx++;

    // R6: unread byte blocks the next single-buffer frame
    send(8'h11);
    wait_tx(n);
    @(negedge clk);
    send(8'h22);
    quiet(40, "R6 stall until read");
    rd(d);
    chk(d == slave_of(fidx), "R6 first data", d, slave_of(fidx));
    fidx++;
    @(negedge clk);
    chk(!sclk, "R6 start after read", sclk, 0);
    wait_tx(n);
    @(negedge clk);
    rd(d);
    chk(d == slave_of(fidx) && cap[fidx] == 8'h22, "R6 second data", d, slave_of(fidx));
    fidx++;

    // R7/R8: double buffering, back-to-back then transmit-empty stall
    dbl_buf = 1'b1;
    send(8'h33);
    send(8'h44);
    wait_tx(n);
    n = 0;
    @(negedge clk); n++;
    rx_ready = 1'b1;
    d = rx_data;
    @(negedge clk); n++;
    rx_ready = 1'b0;
    chk(d == slave_of(fidx), "R7 first data", d, slave_of(fidx));
    fidx++;
    while (!tx_irq) begin @(negedge clk); n++; end
    chk(n == FRAME, "R7 back-to-back spacing", n, FRAME);
    quiet(40, "R8 stall on empty");
    chk(tx_empty, "R8 empty flag", tx_empty, 1);
    rd(d);
    chk(d == slave_of(fidx) && cap[fidx] == 8'h44, "R7 second data", d, slave_of(fidx));
    fidx++;

    // R9: receive-full stall with a waiting byte
    send(8'h55);
    send(8'h66);
    wait_tx(n);
    @(negedge clk);
    wait_tx(n);
    send(8'h77);
    quiet(40, "R9 stall on full");
    chk(rx_full && !rx_irq, "R9 held byte not raised", rx_full, 1);
    rd(d);
    chk(d == slave_of(fidx), "R9 older byte first", d, slave_of(fidx));
    fidx++;
    @(negedge clk);
    chk(rx_irq && rx_data == slave_of(fidx), "R9 waiting byte moves up", rx_data, slave_of(fidx));
    chk(!sclk, "R9 frame resumes", sclk, 0);
    rd(d);
    fidx++;
    wait_tx(n);
    @(negedge clk);
    rd(d);
    chk(d == slave_of(fidx) && cap[fidx] == 8'h77, "R9 resumed frame data", d, slave_of(fidx));

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule